// File: doc/BRIEF.md
# Integer Execute Unit with Carry and Compare Flag

This block is the integer execute stage of a small 32-bit RISC core, built purely as combinational logic. Each cycle it takes two operands and an operation code, together with the carry bit and compare flag currently held in the status word. It returns the result and a write-enable for it, the next carry, the next flag, and a range-exception strobe. The surrounding pipeline stores the result and the flags, and routes the exception to its trap logic.

It covers add, add-with-carry, subtract, multiply, the three bitwise logic operations and the three shifts. It also covers upper-half immediate load, six sign and zero extensions, conditional select on the flag, lowest-set-bit search, and signed and unsigned division. The carry of both additions follows a wrap-detect rule: the carry is set when the unsigned result comes out below the second operand. A separate configuration input lets add, add-with-carry and AND also drive the flag with a zero test. A divide by zero produces no result. Instead it sets carry and raises the range exception.

Top module: `int_alu_core`

## Requirements
- R1: Op 0 (add) gives a+b modulo 2^32, and carry_out is 1 exactly when that sum, taken unsigned, is less than b.
- R2: Op 1 (add-with-carry) gives a+b+carry_in modulo 2^32, and carry_out is 1 exactly when that sum, taken unsigned, is less than b.
- R3: Op 2 gives a-b, op 3 a AND b, op 4 a OR b, op 5 a XOR b, op 20 the low 32 bits of a*b. None of them alters carry, and only op 3 may alter the flag.
- R4: When arith_flag_en is 1, ops 0, 1 and 3 set flag_out to 1 if the result is zero and to 0 otherwise. In every other case flag_out equals flag_in.
- R5: Op 9 gives b[15:0] in result bits 31:16 and zero in bits 15:0.
- R6: Op 6 shifts left, op 7 shifts right logically and op 8 shifts right arithmetically (copying bit 31). All three shift a by b[4:0] only, and none of them alters carry.
- R7: Op 18 (signed divide) or op 19 (unsigned divide) with b equal to zero drives range_exc to 1, carry_out to 1 and result_we to 0.
- R8: Ops 18 and 19 with a non-zero b give the quotient truncated toward zero, keep carry, and hold range_exc at 0.
- R9: Ops 10/11 sign/zero-extend a[7:0], ops 12/13 sign/zero-extend a[15:0], and ops 14/15 pass the 32-bit word through unchanged.
- R10: Op 16 returns a when flag_in is 1 and b when it is 0.
- R11: Op 17 returns the 1-based position of the lowest set bit of a, or 0 when a is zero.
- R12: Every op code from 0 to 20 asserts result_we, except for a zero-divisor divide. Codes 21 to 31 give result 0 and result_we 0, and leave carry and flag unchanged. Only a zero-divisor divide ever raises range_exc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, immediate or shift amount |
| op | input | 5 | Operation code |
| carry_in | input | 1 | Current carry bit |
| flag_in | input | 1 | Current compare flag |
| arith_flag_en | input | 1 | Lets add, add-with-carry and AND write the flag |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result is to be written back |
| carry_out | output | 1 | Next carry bit |
| flag_out | output | 1 | Next compare flag |
| range_exc | output | 1 | Divide-by-zero range exception |

## Verification
Every output is combinational, so each result, flag and exception belongs to the same cycle in which its operands and op code are presented. The bench changes inputs just after a rising clock edge and compares all outputs at the following falling edge. This gives half a period for the logic to settle and keeps every comparison away from the edge where stimulus moves. One vector is applied per cycle, and no result is carried into the next vector's check.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDC  = 5'd1,  OP_SUB   = 5'd2,  OP_AND   = 5'd3,
    OP_OR    = 5'd4,  OP_XOR   = 5'd5,  OP_SLL   = 5'd6,  OP_SRL   = 5'd7,
    OP_SRA   = 5'd8,  OP_HIIMM = 5'd9,  OP_SXB   = 5'd10, OP_ZXB   = 5'd11,
    OP_SXH   = 5'd12, OP_ZXH   = 5'd13, OP_SXW   = 5'd14, OP_ZXW   = 5'd15,
    OP_CSEL  = 5'd16, OP_LSB1  = 5'd17, OP_DIVS  = 5'd18, OP_DIVU  = 5'd19,
    OP_MUL   = 5'd20
  } alu_op_e;

  localparam int unsigned HALF_IMM_W = 16;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         wrap
);
  logic [W-1:0] inc;

  always_comb begin
    inc  = {{(W-1){1'b0}}, use_cin & cin};
    sum  = a + b + inc;
    diff = a - b;
    wrap = (sum < b);
  end
endmodule

// File: rtl/alu_bitfield.sv
module alu_bitfield #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] shl,
  output logic [W-1:0] shr,
  output logic [W-1:0] sar,
  output logic [W-1:0] hiimm,
  output logic [W-1:0] sxb,
  output logic [W-1:0] zxb,
  output logic [W-1:0] sxh,
  output logic [W-1:0] zxh,
  output logic [W-1:0] sxw,
  output logic [W-1:0] zxw,
  output logic [W-1:0] lsb1
);
  localparam int unsigned SH_W  = $clog2(W);
  localparam int unsigned IDX_W = $clog2(W + 1);

  logic [SH_W-1:0]  amt;
  logic [IDX_W-1:0] idx;

  always_comb begin
    amt   = b[SH_W-1:0];
    shl   = a << amt;
    shr   = a >> amt;
    sar   = W'($signed(a) >>> amt);
    hiimm = W'(b[int_alu_pkg::HALF_IMM_W-1:0]) << int_alu_pkg::HALF_IMM_W;
    sxb   = {{(W-8){a[7]}}, a[7:0]};
    zxb   = {{(W-8){1'b0}}, a[7:0]};
    sxh   = {{(W-16){a[15]}}, a[15:0]};
    zxh   = {{(W-16){1'b0}}, a[15:0]};
  end

  generate
    if (W > 32) begin : g_wide
      assign sxw = {{(W-32){a[31]}}, a[31:0]};
      assign zxw = {{(W-32){1'b0}}, a[31:0]};
    end else begin : g_word
      assign sxw = a;
      assign zxw = a;
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i]) idx = IDX_W'(i + 1);
    end
    lsb1 = W'(idx);
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  output logic [W-1:0] quot,
  output logic         by_zero
);
  logic [W-1:0] b_safe;

  always_comb begin
    by_zero = (b == '0);
    b_safe  = by_zero ? {{(W-1){1'b0}}, 1'b1} : b;
    if (is_signed) quot = W'($signed(a) / $signed(b_safe));
    else           quot = a / b_safe;
  end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [4:0]   op,
  input  logic         carry_in,
  input  logic         flag_in,
  input  logic         arith_flag_en,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         carry_out,
  output logic         flag_out,
  output logic         range_exc
);
  import int_alu_pkg::*;

  alu_op_e      opc;
  logic [W-1:0] sum, diff, shl, shr, sar, hiimm;
  logic [W-1:0] sxb, zxb, sxh, zxh, sxw, zxw, lsb1, quot;
  logic         wrap, by_zero;

  assign opc = alu_op_e'(op);

  alu_adder #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .use_cin(opc == OP_ADDC), .cin(carry_in),
    .sum(sum), .diff(diff), .wrap(wrap)
  );

  alu_bitfield #(.W(W)) u_bf (
    .a(opnd_a), .b(opnd_b), .shl(shl), .shr(shr), .sar(sar), .hiimm(hiimm),
    .sxb(sxb), .zxb(zxb), .sxh(sxh), .zxh(zxh), .sxw(sxw), .zxw(zxw),
    .lsb1(lsb1)
  );

  alu_divider #(.W(W)) u_div (
    .a(opnd_a), .b(opnd_b), .is_signed(opc == OP_DIVS),
    .quot(quot), .by_zero(by_zero)
  );

  always_comb begin
    result    = '0;
    result_we = 1'b1;
    carry_out = carry_in;
    flag_out  = flag_in;
    range_exc = 1'b0;
    case (opc)
      OP_ADD, OP_ADDC: begin
        result    = sum;
        carry_out = wrap;
        if (arith_flag_en) flag_out = (sum == '0);
      end
      OP_AND: begin
        result = opnd_a & opnd_b;
        if (arith_flag_en) flag_out = ((opnd_a & opnd_b) == '0);
      end
      OP_SUB:   result = diff;
      OP_OR:    result = opnd_a | opnd_b;
      OP_XOR:   result = opnd_a ^ opnd_b;
      OP_MUL:   result = opnd_a * opnd_b;
      OP_SLL:   result = shl;
      OP_SRL:   result = shr;
      OP_SRA:   result = sar;
      OP_HIIMM: result = hiimm;
      OP_SXB:   result = sxb;
      OP_ZXB:   result = zxb;
      OP_SXH:   result = sxh;
      OP_ZXH:   result = zxh;
      OP_SXW:   result = sxw;
      OP_ZXW:   result = zxw;
      OP_CSEL:  result = flag_in ? opnd_a : opnd_b;
      OP_LSB1:  result = lsb1;
      OP_DIVS, OP_DIVU: begin
        if (by_zero) begin
          result_we = 1'b0;
          carry_out = 1'b1;
          range_exc = 1'b1;
        end else begin
          result = quot;
        end
      end
      default:  result_we = 1'b0;
    endcase
  end

  always_comb begin
    if ((op == 5'd18 || op == 5'd19) && opnd_b == '0) begin
      assert_divzero_trap_R7: assert (range_exc && carry_out && !result_we)
        else $error("zero divisor not trapped");
    end
    if (range_exc) begin
      assert_exc_source_R12: assert (op == 5'd18 || op == 5'd19)
        else $error("range exception outside divide");
    end
    if (!arith_flag_en) begin
      assert_flag_hold_R4: assert (flag_out == flag_in)
        else $error("flag moved with update disabled");
    end
    if (op == 5'd9) begin
      assert_hiimm_low_R5: assert (result[15:0] == 16'h0)
        else $error("upper-immediate low half not zero");
    end
    if (op >= 5'd6 && op <= 5'd8) begin
      assert_shift_carry_R6: assert (carry_out == carry_in)
        else $error("shift altered carry");
    end
  end
endmodule

// File: tb/int_alu_core_test.sv
module int_alu_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] a, b, res;
  logic [4:0]  op;
  logic        cin, fin, fen, we, cout, fout, exc;
  int          n_vec, n_bad;
  bit          done;

  int_alu_core uut (
    .opnd_a(a), .opnd_b(b), .op(op), .carry_in(cin), .flag_in(fin),
    .arith_flag_en(fen), .result(res), .result_we(we), .carry_out(cout),
    .flag_out(fout), .range_exc(exc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input int o);
    case (o)
      0: return "R1";   1: return "R2";
      2, 3, 4, 5, 20: return "R3";
      6, 7, 8: return "R6";  9: return "R5";
      10, 11, 12, 13, 14, 15: return "R9";
      16: return "R10"; 17: return "R11";
      18, 19: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input int o, input logic [31:0] va, input logic [31:0] vb,
                       input logic c, input logic f, input logic e);
    logic [31:0] x_res;
    logic        x_we, x_c, x_f, x_exc;
    string       t;
    @(posedge clk);
    #1;
    op = 5'(o); a = va; b = vb; cin = c; fin = f; fen = e;
    x_res = 32'h0; x_we = 1'b1; x_c = c; x_f = f; x_exc = 1'b0;
    t = tag_of(o);
    case (o)
      0:  begin x_res = va + vb; x_c = (x_res < vb); end
      1:  begin x_res = va + vb + {31'h0, c}; x_c = (x_res < vb); end
      2:  x_res = va - vb;
      3:  x_res = va & vb;
      4:  x_res = va | vb;
      5:  x_res = va ^ vb;
      6:  x_res = va << vb[4:0];
      7:  x_res = va >> vb[4:0];
      8:  begin
            x_res = va >> vb[4:0];
            for (int k = 0; k < 32; k++)
              if (va[31] && k >= 32 - int'(vb[4:0])) x_res[k] = 1'b1;
          end
      9:  x_res = {vb[15:0], 16'h0000};
      10: x_res = 32'(byte'(va[7:0]));
      11: x_res = 32'(va[7:0]);
      12: x_res = 32'(shortint'(va[15:0]));
      13: x_res = 32'(va[15:0]);
      14, 15: x_res = va;
      16: x_res = f ? va : vb;
      17: for (int k = 31; k >= 0; k--) if (va[k]) x_res = 32'(k + 1);
      18, 19: begin
            if (vb == 32'h0) begin
              x_we = 1'b0; x_c = 1'b1; x_exc = 1'b1; t = "R7";
            end else if (o == 19) begin
              x_res = va / vb;
            end else begin
              longint qa, qb, qq;
              qa = longint'(int'(va)); qb = longint'(int'(vb));
              qq = (qa < 0 ? -qa : qa) / (qb < 0 ? -qb : qb);
              if ((qa < 0) != (qb < 0)) qq = -qq;
              x_res = 32'(qq);
            end
          end
      20: x_res = 32'(longint'(va) * longint'(vb));
      default: x_we = 1'b0;
    endcase
    if (e && (o == 0 || o == 1 || o == 3)) x_f = (x_res == 32'h0);
    @(negedge clk);
    n_vec++;
    if (res !== x_res || we !== x_we || cout !== x_c || fout !== x_f || exc !== x_exc) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b f=%b en=%b: got res=%h we=%b c=%b f=%b exc=%b, want res=%h we=%b c=%b f=%b exc=%b%s",
               t, o, va, vb, c, f, e, res, we, cout, fout, exc,
               x_res, x_we, x_c, x_f, x_exc, (fout !== x_f) ? " (flag rule R4)" : "");
    end
  endtask

  initial begin
    logic [31:0] pats [12];
    pats[0] = 32'h0000_0000; pats[1]  = 32'h0000_0001; pats[2]  = 32'hFFFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4]  = 32'h7FFF_FFFF; pats[5]  = 32'h0000_FFFF;
    pats[6] = 32'h1234_5678; pats[7]  = 32'h0000_0080; pats[8]  = 32'h0000_8000;
    pats[9] = 32'h0000_001F; pats[10] = 32'h0000_0021; pats[11] = 32'hA5A5_0F00;
    n_vec = 0; n_bad = 0; done = 1'b0;
    op = 5'd0; a = 32'h0; b = 32'h0; cin = 1'b0; fin = 1'b0; fen = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent vector after reset: add of zeros, R1
    apply(0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    // Corner of the wrap rule, R2: all-ones plus zero plus carry wraps to zero, no carry
    apply(1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1);
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int m = 0; m < 8; m++) begin
            if (o >= 22 && m != 0 && m != 7) continue;
            if (o == 18 && i == 3 && j == 2) continue;
            apply(o, pats[i], pats[j], m[0], m[1], m[2]);
          end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule